// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block drives the bus for an I2C master once a byte has moved. It does two jobs. It clocks out the ninth bit, which is either an acknowledge or a not-acknowledge. It also closes the transaction with a stop condition. Every bus phase lasts one period of an internal baud counter. The counter is reloaded from an 8-bit input and runs for reload+1 system clocks. The next phase starts only when the sampled bus lines confirm the previous one, so a slave that holds SCL low (clock stretching) simply lengthens the sequence.

Software, or a higher-level controller, pulses a request. The matching active bit then stays high until the sequence ends. At that point the bit drops by itself and a sticky interrupt flag is raised. The transmit buffer register sits here too, because a write to it while a sequence is running must be refused. Such a write leaves the buffer untouched and raises a sticky collision flag. The block has no streaming data path, so every pin is a plain level or a one-cycle strobe with no back-pressure.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: One clock edge after `ack_go` is sampled while idle, `scl_pull` is 1, `ack_active` is 1, and `sda_pull` equals the inverse of `ack_nack` (0 = ACK drives SDA low, 1 = NACK leaves it released). The same edge clears `stop_seen`.
- R2: A baud period is `brg_reload`+1 clock cycles. The first acknowledge phase holds SCL low for exactly one period and then releases it.
- R3: With SCL released, the acknowledge waits while `scl_in` is low. On the edge that samples `scl_in` high, it starts one more period. When that period ends, `scl_pull` returns to 1 and stays 1 afterwards, `sda_pull` goes to 0, `ack_active` clears and `irq_flag` sets.
- R4: One edge after `stop_go` is accepted, `stop_active`, `sda_pull` and `scl_pull` are all 1. The block waits for `sda_in` to read low.
- R5: On the edge that samples `sda_in` low, one period starts with SCL still held low. SCL is then released for one period with SDA low, and after that SDA is released.
- R6: On the edge that samples `sda_in` and `scl_in` both high, `stop_seen` sets. One period later, `stop_active` clears and `irq_flag` sets, and both lines remain released.
- R7: If `ack_go` and `stop_go` arrive in the same cycle, or `stop_go` arrives during an acknowledge, the acknowledge runs first. `stop_active` reads 1 from the request onwards. The stop begins on the edge after the acknowledge completes.
- R8: A `buf_wr` while any sequence is active or pending sets `wcol_flag` and leaves `buf_q` unchanged. When idle, `buf_wr` loads `buf_wdata` into `buf_q` on the next edge.
- R9: `irq_flag` and `wcol_flag` hold until a `flag_clr` cycle. A set condition in the same cycle as `flag_clr` wins.
- R10: After reset, both pull outputs, all status bits and both flags are 0, and `buf_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_go | input | 1 | Request pulse: start an acknowledge bit |
| ack_nack | input | 1 | Bit to send: 0 ACK, 1 NACK |
| stop_go | input | 1 | Request pulse: start a stop condition |
| flag_clr | input | 1 | Clears the interrupt and collision flags |
| brg_reload | input | 8 | Baud counter reload value |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| ack_active | output | 1 | Acknowledge in progress (self-clearing) |
| stop_active | output | 1 | Stop pending or in progress (self-clearing) |
| stop_seen | output | 1 | Stop observed on the bus |
| irq_flag | output | 1 | Sticky sequence-complete flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| buf_q | output | 8 | Transmit buffer contents |

## Verification
With a reload value R and no stretching, the bus outputs follow a fixed timeline measured from the request edge k.
- Acknowledge: SCL is released at k+R+1 and pulled low again, with the interrupt set, at k+2R+3. Each cycle of clock stretching pushes the later steps back by one.
- Stop: SCL is released at k+R+2, SDA at k+2R+3, `stop_seen` rises at k+2R+4 and the sequence completes at k+3R+5.

The driver computes these cycle numbers before each request and queues the expected output vector for each of them. The monitor compares on the falling edge of the cycle whose number matches, so every register in the path has already settled. Buffer and flag effects are due one edge after the strobe and are sampled on the next falling edge.

// File: rtl/i2c_as_pkg.sv
package i2c_as_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACK_LOW,
    ST_ACK_REL,
    ST_ACK_HIGH,
    ST_STP_SDA,
    ST_STP_LOW,
    ST_STP_SCLHI,
    ST_STP_REL,
    ST_STP_TAIL
  } seq_st_e;

  function automatic logic is_ack(input seq_st_e s);
    return (s == ST_ACK_LOW) || (s == ST_ACK_REL) || (s == ST_ACK_HIGH);
  endfunction

  function automatic logic is_stop(input seq_st_e s);
    return (s == ST_STP_SDA) || (s == ST_STP_LOW) || (s == ST_STP_SCLHI) ||
           (s == ST_STP_REL) || (s == ST_STP_TAIL);
  endfunction
endpackage

// File: rtl/i2c_as_brg.sv
module i2c_as_brg #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] reload,
  output logic          tick
);
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ZERO;
      run <= 1'b0;
    end else if (load) begin
      cnt <= reload;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == ZERO) run <= 1'b0;
      else             cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == ZERO);

  a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> !tick);
  a_r2_no_early_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (load && reload != ZERO) |=> !tick);
endmodule

// File: rtl/i2c_as_fsm.sv
module i2c_as_fsm
  import i2c_as_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ack_go,
  input  logic ack_nack,
  input  logic stop_go,
  input  logic scl_in,
  input  logic sda_in,
  input  logic tick,
  output logic brg_load,
  output logic scl_pull,
  output logic sda_pull,
  output logic ack_active,
  output logic stop_active,
  output logic stop_seen,
  output logic busy,
  output logic seq_done
);
  seq_st_e st, nxt;
  logic    nack_q;
  logic    stop_pend;
  logic    scl_hold;

  always_comb begin
    nxt      = st;
    brg_load = 1'b0;
    seq_done = 1'b0;
    case (st)
      ST_IDLE: begin
        if (ack_go) begin
          nxt      = ST_ACK_LOW;
          brg_load = 1'b1;
        end else if (stop_go || stop_pend) begin
          nxt = ST_STP_SDA;
        end
      end
      ST_ACK_LOW:  if (tick) nxt = ST_ACK_REL;
      ST_ACK_REL: begin
        if (scl_in) begin
          nxt      = ST_ACK_HIGH;
          brg_load = 1'b1;
        end
      end
      ST_ACK_HIGH: begin
        if (tick) begin
          nxt      = ST_IDLE;
          seq_done = 1'b1;
        end
      end
      ST_STP_SDA: begin
        if (!sda_in) begin
          nxt      = ST_STP_LOW;
          brg_load = 1'b1;
        end
      end
      ST_STP_LOW: begin
        if (tick) begin
          nxt      = ST_STP_SCLHI;
          brg_load = 1'b1;
        end
      end
      ST_STP_SCLHI: if (tick) nxt = ST_STP_REL;
      ST_STP_REL: begin
        if (sda_in && scl_in) begin
          nxt      = ST_STP_TAIL;
          brg_load = 1'b1;
        end
      end
      ST_STP_TAIL: begin
        if (tick) begin
          nxt      = ST_IDLE;
          seq_done = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      nack_q    <= 1'b1;
      stop_pend <= 1'b0;
      scl_hold  <= 1'b0;
      stop_seen <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && ack_go) nack_q <= ack_nack;
      if (st == ST_IDLE && nxt == ST_STP_SDA)
        stop_pend <= 1'b0;
      else if (stop_go && (is_ack(st) || (st == ST_IDLE && ack_go)))
        stop_pend <= 1'b1;
      if (st == ST_ACK_HIGH && tick)      scl_hold <= 1'b1;
      else if (st == ST_STP_TAIL && tick) scl_hold <= 1'b0;
      if (st == ST_IDLE && nxt != ST_IDLE)          stop_seen <= 1'b0;
      else if (st == ST_STP_REL && nxt == ST_STP_TAIL) stop_seen <= 1'b1;
    end
  end

  always_comb begin
    case (st)
      ST_IDLE:                scl_pull = scl_hold;
      ST_ACK_LOW, ST_STP_SDA,
      ST_STP_LOW:             scl_pull = 1'b1;
      default:                scl_pull = 1'b0;
    endcase
    if (is_ack(st))
      sda_pull = !nack_q;
    else
      sda_pull = (st == ST_STP_SDA) || (st == ST_STP_LOW) || (st == ST_STP_SCLHI);
  end

  assign ack_active  = is_ack(st);
  assign stop_active = is_stop(st) || stop_pend;
  assign busy        = (st != ST_IDLE) || stop_pend;

  a_r1_ack_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && ack_go) |=> (scl_pull && ack_active && (sda_pull == !$past(ack_nack))));
  a_r3_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK_REL && !scl_in) |=> (st == ST_ACK_REL && !scl_pull));
  a_r3_ack_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK_HIGH && tick) |=> (!ack_active && scl_pull && !sda_pull));
  a_r4_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STP_SDA) |-> (sda_pull && scl_pull && stop_active));
  a_r5_scl_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STP_SCLHI) |-> (!scl_pull && sda_pull));
  a_r6_seen_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> $past(sda_in && scl_in));
  a_r7_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && ack_go && stop_go) |=> (ack_active && stop_active));
endmodule

// File: rtl/i2c_as_flags.sv
module i2c_as_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          seq_done,
  input  logic          flag_clr,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  output logic          irq_flag,
  output logic          wcol_flag,
  output logic [DW-1:0] buf_q
);
  logic collide;
  assign collide = buf_wr && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag  <= 1'b0;
      wcol_flag <= 1'b0;
      buf_q     <= '0;
    end else begin
      if (seq_done)      irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
      if (collide)       wcol_flag <= 1'b1;
      else if (flag_clr) wcol_flag <= 1'b0;
      if (buf_wr && !busy) buf_q <= buf_wdata;
    end
  end

  a_r8_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy) |=> (wcol_flag && $stable(buf_q)));
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && !busy) |=> (buf_q == $past(buf_wdata)));
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);
  a_r9_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !seq_done) |=> !irq_flag);
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq #(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_go,
  input  logic          ack_nack,
  input  logic          stop_go,
  input  logic          flag_clr,
  input  logic [CW-1:0] brg_reload,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          ack_active,
  output logic          stop_active,
  output logic          stop_seen,
  output logic          irq_flag,
  output logic          wcol_flag,
  output logic [DW-1:0] buf_q
);
  logic tick, brg_load, busy, seq_done;

  i2c_as_brg #(.CW(CW)) u_brg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (brg_load),
    .reload (brg_reload),
    .tick   (tick)
  );

  i2c_as_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_go      (ack_go),
    .ack_nack    (ack_nack),
    .stop_go     (stop_go),
    .scl_in      (scl_in),
    .sda_in      (sda_in),
    .tick        (tick),
    .brg_load    (brg_load),
    .scl_pull    (scl_pull),
    .sda_pull    (sda_pull),
    .ack_active  (ack_active),
    .stop_active (stop_active),
    .stop_seen   (stop_seen),
    .busy        (busy),
    .seq_done    (seq_done)
  );

  i2c_as_flags #(.DW(DW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .seq_done  (seq_done),
    .flag_clr  (flag_clr),
    .buf_wr    (buf_wr),
    .buf_wdata (buf_wdata),
    .irq_flag  (irq_flag),
    .wcol_flag (wcol_flag),
    .buf_q     (buf_q)
  );

  a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_active && !stop_active) |-> !sda_pull);
endmodule

// File: tb/i2c_ackstop_seq_test.sv
module i2c_ackstop_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_go = 1'b0, ack_nack = 1'b0, stop_go = 1'b0, flag_clr = 1'b0;
  logic [7:0] brg_reload = 8'd3;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_wdata = 8'd0;
  logic       stretch = 1'b0;
  logic       scl_in, sda_in;
  logic       scl_pull, sda_pull, ack_active, stop_active, stop_seen, irq_flag, wcol_flag;
  logic [7:0] buf_q;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int         q_cyc[$];
  logic [5:0] q_vec[$];
  string      q_req[$];

  assign scl_in = !scl_pull && !stretch;
  assign sda_in = !sda_pull;

  i2c_ackstop_seq uut (
    .clk(clk), .rst_n(rst_n), .ack_go(ack_go), .ack_nack(ack_nack), .stop_go(stop_go),
    .flag_clr(flag_clr), .brg_reload(brg_reload), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .ack_active(ack_active), .stop_active(stop_active), .stop_seen(stop_seen),
    .irq_flag(irq_flag), .wcol_flag(wcol_flag), .buf_q(buf_q)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  // expected vector: {scl_pull, sda_pull, ack_active, stop_active, stop_seen, irq_flag}
  task automatic expect_at(input int c, input logic [5:0] v, input string req);
    q_cyc.push_back(c);
    q_vec.push_back(v);
    q_req.push_back(req);
  endtask

  // monitor: pop scoreboard entries as their cycle arrives
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      if (q_cyc[0] < cyc) begin
        total++; bad++;
        $display("FAIL %s: entry for cycle %0d missed", q_req[0], q_cyc[0]);
      end else begin
        check(q_req[0], {2'b0, scl_pull, sda_pull, ack_active, stop_active, stop_seen, irq_flag},
              {2'b0, q_vec[0]});
      end
      void'(q_cyc.pop_front());
      void'(q_vec.pop_front());
      void'(q_req.pop_front());
    end
  end

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic do_ack(input logic nack, input int s);
    int k, r;
    clear_flags();
    r = int'(brg_reload);
    @(negedge clk);
    k = cyc + 1;
    ack_go = 1'b1; ack_nack = nack;
    if (s > 0) stretch = 1'b1;
    expect_at(k,         {1'b1, !nack, 4'b1000}, "R1");
    expect_at(k + r,     {1'b1, !nack, 4'b1000}, "R2");
    expect_at(k + r + 1, {1'b0, !nack, 4'b1000}, "R2");
    expect_at(k + 2*r + 2 + s, {1'b0, !nack, 4'b1000}, "R3");
    expect_at(k + 2*r + 3 + s, 6'b100001, "R3");
    @(negedge clk); ack_go = 1'b0;
    if (s > 0) begin
      wait_cyc(k + r + 1 + s);
      stretch = 1'b0;
    end
    wait_cyc(k + 2*r + 5 + s);
  endtask

  task automatic do_stop();
    int k, r;
    clear_flags();
    r = int'(brg_reload);
    @(negedge clk);
    k = cyc + 1;
    stop_go = 1'b1;
    expect_at(k,             6'b110100, "R4");
    expect_at(k + r + 1,     6'b110100, "R5");
    expect_at(k + r + 2,     6'b010100, "R5");
    expect_at(k + 2*r + 2,   6'b010100, "R5");
    expect_at(k + 2*r + 3,   6'b000100, "R5");
    expect_at(k + 2*r + 4,   6'b000110, "R6");
    expect_at(k + 3*r + 4,   6'b000110, "R6");
    expect_at(k + 3*r + 5,   6'b000011, "R6");
    @(negedge clk); stop_go = 1'b0;
    wait_cyc(k + 3*r + 7);
  endtask

  task automatic do_both();
    int k, r, a;
    clear_flags();
    r = int'(brg_reload);
    @(negedge clk);
    k = cyc + 1;
    ack_go = 1'b1; ack_nack = 1'b1; stop_go = 1'b1;
    a = k + 2*r + 3;
    expect_at(k,             6'b101100, "R7");
    expect_at(k + r + 1,     6'b001100, "R7");
    expect_at(a,             6'b100101, "R7");
    expect_at(a + 1,         6'b110101, "R7");
    expect_at(a + 1 + 2*r + 3, 6'b000101, "R7");
    expect_at(a + 1 + 3*r + 5, 6'b000011, "R7");
    @(negedge clk); ack_go = 1'b0; stop_go = 1'b0;
    wait_cyc(a + 3*r + 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", {2'b0, scl_pull, sda_pull, ack_active, stop_active, stop_seen, irq_flag}, 8'h00);
    check("R10", {7'b0, wcol_flag}, 8'h00);
    check("R10", buf_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: idle write lands
    buf_wr = 1'b1; buf_wdata = 8'h3C;
    @(negedge clk); buf_wr = 1'b0;
    check("R8", buf_q, 8'h3C);
    check("R8", {7'b0, wcol_flag}, 8'h00);

    brg_reload = 8'd3;
    do_ack(1'b0, 0);
    do_ack(1'b1, 4);
    do_stop();
    brg_reload = 8'd0;
    do_ack(1'b0, 0);
    do_stop();
    brg_reload = 8'd5;
    do_both();

    // R8/R9: collision while acknowledge is held by stretching
    brg_reload = 8'd2;
    clear_flags();
    stretch = 1'b1;
    @(negedge clk); ack_go = 1'b1; ack_nack = 1'b0;
    @(negedge clk); ack_go = 1'b0;
    repeat (5) @(negedge clk);
    check("R3", {7'b0, ack_active}, 8'h01);
    buf_wr = 1'b1; buf_wdata = 8'hA5;
    @(negedge clk); buf_wr = 1'b0;
    check("R8", {7'b0, wcol_flag}, 8'h01);
    check("R8", buf_q, 8'h3C);
    buf_wr = 1'b1; flag_clr = 1'b1;
    @(negedge clk); buf_wr = 1'b0; flag_clr = 1'b0;
    check("R9", {7'b0, wcol_flag}, 8'h01);
    check("R8", buf_q, 8'h3C);
    repeat (3) @(negedge clk);
    check("R9", {7'b0, wcol_flag}, 8'h01);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R9", {7'b0, wcol_flag}, 8'h00);
    stretch = 1'b0;
    repeat (10) @(negedge clk);
    check("R3", {6'b0, ack_active, irq_flag}, 8'h01);
    repeat (4) @(negedge clk);
    check("R9", {7'b0, irq_flag}, 8'h01);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R9", {7'b0, irq_flag}, 8'h00);
    buf_wr = 1'b1; buf_wdata = 8'hA5;
    @(negedge clk); buf_wr = 1'b0;
    check("R8", buf_q, 8'hA5);
    check("R8", {7'b0, wcol_flag}, 8'h00);

    repeat (3) @(negedge clk);
    if (q_cyc.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d entries unchecked", q_cyc.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule